// File: doc/BRIEF.md
# Data Bus Line Tester

This engine sits beside a single-port synchronous memory and checks the data wires between the two for shorts and opens. One start pulse runs a fixed sequence of wide test words. The words are chosen so that every pair of data lines is driven to opposite levels at some point, whatever order the lines are routed in. Each word is also used in inverted form.

Each word is written to one base location. A fixed guard word is then written to the next location up, so a bus that floats cannot keep the test value on its wires. The base location is then read back exactly once, and only that returned value is compared.

The engine always runs every word, even after a mismatch. At the end it reports pass or fail together with a record of the first mismatch: which word failed, at what address, the value written and the value read. That record stays unchanged until the next accepted start.

Top module: `dbus_line_tester`

## Requirements
- R1: The test words are applied in a fixed order of twelve for a 64-bit bus. Word k for k<6 has bit i equal to bit k of i: 0xAAAA..., 0xCCCC..., 0xF0F0..., 0xFF00FF00..., 0xFFFF0000FFFF0000, 0xFFFFFFFF00000000. Word k for k>=6 is the bitwise inverse of word 11-k, so the sequence ends with 0x00000000FFFFFFFF and continues down to 0x5555....
- R2: For each word, the engine issues requests in three consecutive cycles. First, a write of the word to the base address. Second, a write of 0x0123456789ABCDEF to base+1. Third, a read of the base address. A write request lasts one cycle.
- R3: Each word gets exactly one read request, and no further request follows it until a response returns. The value compared is the read data present in the first cycle that mem_rvalid is high after that request, however many cycles later that is.
- R4: mem_rvalid, together with its data, has no effect when no read is outstanding.
- R5: A mismatch does not stop the sequence. fail rises in the cycle after the first mismatching response and stays high until the next accepted start.
- R6: fail_idx, fail_addr, fail_exp and fail_obs hold the word index (0 to 11 in R1 order), the base address, the written word and the read word of the first mismatch only. Later mismatches leave them unchanged. An accepted start clears them to zero.
- R7: done is high for exactly one cycle, the cycle after the last response. busy falls in that same cycle, and no request is presented then.
- R8: A start while busy is high is ignored. A start while busy is low is accepted, including in the done cycle. In the cycle after an accepted start, busy is high and the first write request is presented.
- R9: While reset is high, busy, done, fail and mem_req are low.
- R10: base_addr is sampled when a start is accepted. Later changes to base_addr do not affect the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a run |
| base_addr | input | ADDR_W | Word address of the target location |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | At least one word mismatched |
| fail_idx | output | IDX_W | Index of the first failing word |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_exp | output | DATA_W | Word written at the first mismatch |
| fail_obs | output | DATA_W | Word read back at the first mismatch |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Request word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read response data |
| mem_rvalid | input | 1 | Read response valid |

## Verification
Two events can coincide in one cycle, and the bench provokes both pairings on purpose.

The first pairing is the final comparison and the end of the run. A bench-side fault corrupts only the twelfth readback, so the first-failure record must show index 11 in the same cycle that done pulses.

The second pairing is a new start and the done pulse. The bench raises start during the done cycle and checks that the new run is accepted and that the stale failure record clears one cycle later. It also raises a start in the middle of a run, together with a changed base address, and checks that neither disturbs the request stream.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WPAT  = 3'd1,
    ST_WGRD  = 3'd2,
    ST_RREQ  = 3'd3,
    ST_RWAIT = 3'd4
  } dbt_state_e;
endpackage

// File: rtl/dbt_pattern_gen.sv
module dbt_pattern_gen #(
  parameter int DATA_W = 64,
  parameter int LOG_W  = 6,
  parameter int NPAT   = 12,
  parameter int IDX_W  = 4
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] word
);
  logic [DATA_W-1:0] tbl [NPAT];

  // first half: bit b carries bit p of b; second half: mirrored inverse
  for (genvar p = 0; p < NPAT; p++) begin : g_pat
    localparam int SEL = (p < LOG_W) ? p : (NPAT - 1 - p);
    localparam bit INV = (p >= LOG_W);
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      localparam bit BITV = (((b >> SEL) & 1) == 1) ^ INV;
      assign tbl[p][b] = BITV;
    end
  end

  always_comb begin
    word = '0;
    for (int p = 0; p < NPAT; p++) begin
      if (idx == IDX_W'(p)) word = tbl[p];
    end
  end
endmodule

// File: rtl/dbt_sequencer.sv
module dbt_sequencer
  import dbt_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 16,
  parameter int NPAT   = 12,
  parameter int IDX_W  = 4,
  parameter logic [DATA_W-1:0] GUARD = 64'h0123_4567_89AB_CDEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              rvalid,
  input  logic [DATA_W-1:0] pat_nxt,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [IDX_W-1:0]  nxt_idx,
  output logic [ADDR_W-1:0] run_base,
  output logic              start_acc,
  output logic              cmp_valid,
  output logic              busy,
  output logic              done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NPAT - 1);

  dbt_state_e        state;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] base_q;

  assign cur_idx   = idx;
  assign nxt_idx   = (state == ST_IDLE) ? '0 : idx + 1'b1;
  assign run_base  = base_q;
  assign start_acc = (state == ST_IDLE) && start;
  assign cmp_valid = (state == ST_RWAIT) && rvalid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      idx       <= '0;
      base_q    <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            base_q    <= base_addr;
            idx       <= '0;
            busy      <= 1'b1;
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= base_addr;
            mem_wdata <= pat_nxt;
            state     <= ST_WPAT;
          end
        end
        ST_WPAT: begin
          mem_addr  <= base_q + 1'b1;
          mem_wdata <= GUARD;
          state     <= ST_WGRD;
        end
        ST_WGRD: begin
          mem_we    <= 1'b0;
          mem_addr  <= base_q;
          mem_wdata <= '0;
          state     <= ST_RREQ;
        end
        ST_RREQ: begin
          mem_req <= 1'b0;
          state   <= ST_RWAIT;
        end
        ST_RWAIT: begin
          if (rvalid) begin
            if (idx == LAST) begin
              busy  <= 1'b0;
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              idx       <= idx + 1'b1;
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= base_q;
              mem_wdata <= pat_nxt;
              state     <= ST_WPAT;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbt_fail_capture.sv
module dbt_fail_capture #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              cmp_valid,
  input  logic [IDX_W-1:0]  cmp_idx,
  input  logic [ADDR_W-1:0] cmp_addr,
  input  logic [DATA_W-1:0] exp_word,
  input  logic [DATA_W-1:0] obs_word,
  output logic              fail,
  output logic [IDX_W-1:0]  fail_idx,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_exp,
  output logic [DATA_W-1:0] fail_obs
);
  logic mismatch;
  assign mismatch = cmp_valid && (obs_word != exp_word);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      fail      <= 1'b0;
      fail_idx  <= '0;
      fail_addr <= '0;
      fail_exp  <= '0;
      fail_obs  <= '0;
    end else if (mismatch && !fail) begin
      fail      <= 1'b1;
      fail_idx  <= cmp_idx;
      fail_addr <= cmp_addr;
      fail_exp  <= exp_word;
      fail_obs  <= obs_word;
    end
  end
endmodule

// File: rtl/dbus_line_tester.sv
module dbus_line_tester #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 16,
  parameter logic [DATA_W-1:0] GUARD = 64'h0123_4567_89AB_CDEF,
  localparam int LOG_W = $clog2(DATA_W),
  localparam int NPAT  = 2 * LOG_W,
  localparam int IDX_W = $clog2(NPAT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [IDX_W-1:0]  fail_idx,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_exp,
  output logic [DATA_W-1:0] fail_obs,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_rvalid
);
  logic [IDX_W-1:0]  cur_idx, nxt_idx;
  logic [DATA_W-1:0] pat_cur, pat_nxt;
  logic [ADDR_W-1:0] run_base;
  logic              start_acc, cmp_valid;

  dbt_pattern_gen #(.DATA_W(DATA_W), .LOG_W(LOG_W), .NPAT(NPAT), .IDX_W(IDX_W))
    u_pat_cur (.idx(cur_idx), .word(pat_cur));

  dbt_pattern_gen #(.DATA_W(DATA_W), .LOG_W(LOG_W), .NPAT(NPAT), .IDX_W(IDX_W))
    u_pat_nxt (.idx(nxt_idx), .word(pat_nxt));

  dbt_sequencer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NPAT(NPAT), .IDX_W(IDX_W),
                  .GUARD(GUARD))
    u_seq (
      .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
      .rvalid(mem_rvalid), .pat_nxt(pat_nxt),
      .cur_idx(cur_idx), .nxt_idx(nxt_idx), .run_base(run_base),
      .start_acc(start_acc), .cmp_valid(cmp_valid),
      .busy(busy), .done(done),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

  dbt_fail_capture #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W))
    u_cap (
      .clk(clk), .rst(rst), .clear(start_acc), .cmp_valid(cmp_valid),
      .cmp_idx(cur_idx), .cmp_addr(run_base), .exp_word(pat_cur), .obs_word(mem_rdata),
      .fail(fail), .fail_idx(fail_idx), .fail_addr(fail_addr),
      .fail_exp(fail_exp), .fail_obs(fail_obs)
    );
endmodule

// File: rtl/dbt_chk.sv
module dbt_chk #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter logic [DATA_W-1:0] GUARD = 64'h0123_4567_89AB_CDEF
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic [IDX_W-1:0]  fail_idx,
  input logic [DATA_W-1:0] fail_obs,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata
);
  // R2
  guard_after_pat_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_wdata != GUARD) |=>
      (mem_req && mem_we && mem_wdata == GUARD &&
       mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

  // R2
  read_after_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_wdata == GUARD) |=>
      (mem_req && !mem_we && mem_addr == ADDR_W'($past(mem_addr) - 1'b1)));

  // R3
  single_read_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |=> !mem_req);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !mem_req));

  // R8
  start_take_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && mem_req && mem_we));

  // R6
  record_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(fail) && $stable(fail_idx) && $stable(fail_obs)));
endmodule

bind dbus_line_tester dbt_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .GUARD(GUARD)
) chk_i (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .fail(fail),
  .fail_idx(fail_idx), .fail_obs(fail_obs), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/dbus_line_tester_tb_top.sv
module dbus_line_tester_tb_top;
  localparam int DW = 64;
  localparam int AW = 16;
  localparam int IW = 4;
  localparam logic [63:0] GRD = 64'h0123_4567_89AB_CDEF;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic          busy, done, fail;
  logic [IW-1:0] fail_idx;
  logic [AW-1:0] fail_addr;
  logic [DW-1:0] fail_exp, fail_obs;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_rvalid = 1'b0;

  dbus_line_tester dut_i (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
    .busy(busy), .done(done), .fail(fail), .fail_idx(fail_idx),
    .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_obs(fail_obs),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
  );

  logic [63:0] pats [12] = '{
    64'hAAAA_AAAA_AAAA_AAAA, 64'hCCCC_CCCC_CCCC_CCCC, 64'hF0F0_F0F0_F0F0_F0F0,
    64'hFF00_FF00_FF00_FF00, 64'hFFFF_0000_FFFF_0000, 64'hFFFF_FFFF_0000_0000,
    64'h0000_0000_FFFF_FFFF, 64'h0000_FFFF_0000_FFFF, 64'h00FF_00FF_00FF_00FF,
    64'h0F0F_0F0F_0F0F_0F0F, 64'h3333_3333_3333_3333, 64'h5555_5555_5555_5555};

  typedef struct { int kind; logic [AW-1:0] a; logic [DW-1:0] d; } op_t;
  op_t q[$];

  logic [63:0] mem [int];
  logic [63:0] f_s1 = '0, f_s0 = '0, f_float = '0, bus_last = '0;
  int          f_flip = -1, lat = 1, rd_count = 0, pend = 0, strays = 0;
  bit          stray_en = 0, rd_out = 0, restart_on_done = 0, start_cmd = 0;
  logic [AW-1:0] base_cmd = '0;

  bit            m_busy, m_done, m_fail, m_req_next;
  int            m_k, m_fidx;
  logic [AW-1:0] m_base, m_faddr;
  logic [63:0]   m_fexp, m_fobs;

  int total = 0, bad = 0, cyc = 0;

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic push_ops(int k);
    q.push_back('{0, m_base, pats[k]});
    q.push_back('{1, m_base + 16'd1, GRD});
    q.push_back('{2, m_base, 64'h0});
  endtask

  function automatic logic [63:0] read_word();
    logic [63:0] w;
    w = mem.exists(int'(m_base)) ? mem[int'(m_base)] : 64'h0;
    w = (w | f_s1) & ~f_s0;
    w = (w & ~f_float) | (bus_last & f_float);
    if (rd_count == f_flip) w = w ^ (64'h1 << 40);
    return w;
  endfunction

  task automatic model_reset();
    m_busy = 0; m_done = 0; m_fail = 0; m_req_next = 0; m_k = 0;
    m_fidx = 0; m_base = '0; m_faddr = '0; m_fexp = '0; m_fobs = '0;
    q.delete(); rd_out = 0; pend = 0;
  endtask

  always @(negedge clk) begin
    logic [63:0] rd;
    bit rv_now, stray_now, pre_busy;
    op_t op;
    if (rst) begin
      model_reset();
      start = 0; mem_rvalid = 0;
      if (cyc > 1)
        chk(!busy && !done && !fail && !mem_req, "R9", "outputs during reset",
            {60'h0, busy, done, fail, mem_req}, 64'h0);
    end else begin
      chk(busy === m_busy, "R8", "busy", {63'h0, busy}, {63'h0, m_busy});
      chk(done === m_done, "R7", "done", {63'h0, done}, {63'h0, m_done});
      chk(fail === m_fail, "R5", "fail", {63'h0, fail}, {63'h0, m_fail});
      chk(fail_idx === IW'(m_fidx), "R6", "fail_idx", {60'h0, fail_idx}, 64'(m_fidx));
      chk(fail_addr === m_faddr, "R6", "fail_addr", {48'h0, fail_addr}, {48'h0, m_faddr});
      chk(fail_exp === m_fexp, "R6", "fail_exp", fail_exp, m_fexp);
      chk(fail_obs === m_fobs, "R6", "fail_obs", fail_obs, m_fobs);
      if (m_req_next) chk(mem_req === 1'b1, "R2", "request expected this cycle", {63'h0, mem_req}, 64'h1);
      m_req_next = 0;

      rv_now = 0; stray_now = 0; rd = '0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin rv_now = 1; rd = read_word(); rd_count++; end
      end

      if (mem_req) begin
        if (q.size() == 0) begin
          chk(0, "R3", "unexpected request", {48'h0, mem_addr}, 64'h0);
        end else begin
          op = q.pop_front();
          if (op.kind == 0)
            chk(mem_we === 1'b1 && mem_addr === op.a && mem_wdata === op.d, "R1",
                "pattern write", mem_wdata, op.d);
          else if (op.kind == 1)
            chk(mem_we === 1'b1 && mem_addr === op.a && mem_wdata === op.d, "R2",
                "guard write", {mem_addr, mem_wdata[47:0]}, {op.a, op.d[47:0]});
          else
            chk(mem_we === 1'b0 && mem_addr === op.a, "R3", "read request",
                {48'h0, mem_addr}, {48'h0, op.a});
          if (op.kind != 2) m_req_next = 1;
        end
        if (mem_we) begin
          mem[int'(mem_addr)] = mem_wdata;
          bus_last = mem_wdata;
          if (stray_en && !rd_out && pend == 0 && !rv_now) begin
            rv_now = 1; stray_now = 1; rd = 64'hDEAD_BEEF_DEAD_BEEF; strays++;
          end
        end else begin
          chk(!rd_out, "R3", "read while one outstanding", 64'h1, 64'h0);
          rd_out = 1; pend = lat;
        end
      end
      mem_rvalid = rv_now;
      mem_rdata  = rv_now ? rd : 64'h0;

      start = start_cmd; start_cmd = 0;
      base_addr = base_cmd;
      if (m_done && restart_on_done) begin
        start = 1; restart_on_done = 0;
        f_s1 = '0; f_s0 = '0; f_float = '0; f_flip = -1;
      end

      pre_busy = m_busy; m_done = 0;
      if (rv_now && !stray_now) begin
        rd_out = 0;
        if (rd !== pats[m_k]) begin
          if (!m_fail) begin
            m_fidx = m_k; m_faddr = m_base; m_fexp = pats[m_k]; m_fobs = rd;
          end
          m_fail = 1;
        end
        m_k++;
        if (m_k == 12) begin m_done = 1; m_busy = 0; end
        else begin push_ops(m_k); m_req_next = 1; end
      end
      if (start && !pre_busy) begin
        m_busy = 1; m_fail = 0; m_fidx = 0; m_faddr = '0; m_fexp = '0; m_fobs = '0;
        m_k = 0; m_base = base_addr; q.delete(); rd_count = 0; m_req_next = 1;
        push_ops(0);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++; bad++;
      $display("FAIL watchdog: run hung act=%0d exp=%0d", cyc, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic go(logic [AW-1:0] b);
    @(posedge clk); #1;
    base_cmd = b; start_cmd = 1;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (done !== 1'b1);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;

    // clean memory, one-cycle latency
    lat = 1; go(16'h0010); wait_done();
    chk(fail === 1'b0, "R5", "clean run passes", {63'h0, fail}, 64'h0);

    // stuck-high line 15, stray responses during writes
    @(posedge clk); #1;
    f_s1 = 64'h8000; lat = 2; stray_en = 1;
    go(16'h0200); wait_done();
    chk(fail === 1'b1 && fail_idx === 4'd4, "R4", "stuck line first fail index",
        {60'h0, fail_idx}, 64'd4);
    chk(strays > 0, "R4", "stray responses injected", 64'(strays), 64'd1);

    // floating byte lane 2, start while busy, then restart in the done cycle
    @(posedge clk); #1;
    f_s1 = '0; f_float = 64'h0000_0000_00FF_0000; lat = 3;
    go(16'h1234);
    repeat (5) @(posedge clk);
    #1 start_cmd = 1; base_cmd = 16'h0BAD;
    @(posedge clk); #1 restart_on_done = 1;
    wait_done();
    chk(fail_idx === 4'd0 && fail_obs === 64'hAAAA_AAAA_AAAB_AAAA, "R6",
        "floating lane record", fail_obs, 64'hAAAA_AAAA_AAAB_AAAA);
    chk(fail_addr === 16'h1234, "R10", "base sampled at start", {48'h0, fail_addr}, 64'h1234);
    @(negedge clk);
    chk(busy === 1'b1 && fail === 1'b0, "R8", "restart in done cycle",
        {62'h0, busy, fail}, 64'h2);
    wait_done();
    chk(fail === 1'b0, "R5", "clean rerun passes", {63'h0, fail}, 64'h0);

    // only the last readback is corrupted, top address
    @(posedge clk); #1;
    stray_en = 0; f_flip = 11; lat = 2;
    go(16'hFFFE); wait_done();
    chk(fail === 1'b1 && fail_idx === 4'd11, "R7", "last-word fail with done",
        {60'h0, fail_idx}, 64'd11);
    chk(fail_exp === 64'h5555_5555_5555_5555, "R1", "last word value", fail_exp,
        64'h5555_5555_5555_5555);

    repeat (4) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule